// File: doc/BRIEF.md
# Master-Mode Serial Audio Port (I2S / TDM)

This block is the clock-generating end of a serial audio link. From the system clock it derives a bit clock and a word-select signal. In two-channel mode the word-select is a left/right level. In eight-channel mode it is a one-bit frame-sync pulse. It shifts parallel 32-bit samples out on one or more serial data lines and gathers the serial input lines back into 32-bit samples. All lines share one slot timing. A parameter sets the slot length to 16 or 32 bits. In 16-bit mode samples stay left-aligned in the 32-bit words.

The user side exchanges one sample word per slot in each direction, and each word covers every line at once. The exchange uses a valid/ready handshake. Each side has a one-word holding register, and a slot number tells the user which channel the word belongs to. If the transmit side runs dry, the slot is sent as zeros and a one-cycle flag is raised. If a received word is not taken before the next word completes, it is replaced by the newer word and a one-cycle flag is raised.

Top module: `aport_master`

## Requirements
- R1: `bclk_o` has a period of `div_i` clock cycles (`div_i` even, at least 2), with equal high and low halves, and it is low coming out of reset.
- R2: While reset is held and just after it is released, `bclk_o`, `lrck_o`, `sd_o`, `tx_underflow`, `rx_valid` and `rx_overflow` are 0, `tx_ready` is 1 and `tx_chan` is 0. `sd_o` stays 0 until the first bit of the first slot is driven.
- R3: With `TDM_MODE`=0 each line carries 2 slots per frame. `lrck_o` is 0 across slot 0 (left) and 1 across slot 1 (right). It switches on the last bit of the preceding slot, so each slot's first data bit follows the `lrck_o` change by one bit period.
- R4: With `TDM_MODE`=1 each line carries 8 slots per frame. `lrck_o` is a frame-sync pulse that is 1 for exactly one bit period, the last bit of slot 7, and 0 at every other bit. Slot 0's first data bit follows it by one bit period.
- R5: Transmit data goes out MSB first. `WORD_BITS` must be 16 or 32, and any other value stops elaboration. In 16-bit mode bits 31:16 of the sample are sent.
- R6: Receive data is sampled on `bclk_o` rising edges, MSB first. The completed slot is presented as a 32-bit sample with the received bits at the top. In 16-bit mode bits 15:0 are zero.
- R7: Within a frame, slot s below half the slot count carries local channel 2s, and slot s at or above half carries channel 2(s-half)+1. `tx_chan` gives the channel of the next slot to be loaded from the transmit register. `rx_chan` gives the channel of the word on `rx_data`.
- R8: Line l uses bits [32l+31:32l] of `tx_data` and `rx_data`, and all lines change at the same bit-clock edges.
- R9: When a slot starts and no transmit sample is held, `tx_underflow` pulses for one cycle and that slot is sent as all zeros. An accepted sample drops `tx_ready` until that sample is consumed.
- R10: When a received word completes while the previous one is still unaccepted, `rx_overflow` pulses for one cycle, the newer word replaces the old one, and `rx_valid` stays 1.
- R11: `lrck_o` and `sd_o` change only in the cycle in which `bclk_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Bit-clock period in clock cycles, even, at least 2 |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Left/right select or one-bit frame sync |
| sd_o | output | LINES | Serial data out, one bit per line |
| sd_i | input | LINES | Serial data in, one bit per line |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 32*LINES | Transmit sample, one 32-bit word per line |
| tx_chan | output | CH_W | Channel number of the next slot to be loaded |
| tx_underflow | output | 1 | One-cycle pulse: a slot started with no sample |
| rx_valid | output | 1 | Received sample waiting |
| rx_ready | input | 1 | User takes the received sample |
| rx_data | output | 32*LINES | Received sample, one 32-bit word per line |
| rx_chan | output | CH_W | Channel number of the received sample |
| rx_overflow | output | 1 | One-cycle pulse: an unaccepted sample was replaced |

## Verification
The bench runs two configurations side by side. The first is two-line, 32-bit, two-channel framing. The second is one-line, 16-bit, eight-channel framing. Each has its serial output looped back to its input.

The sample table mixes single-MSB, single-LSB, all-ones, all-zeros, alternating and irregular words. On line 1 the 16-bit halves are swapped, so a bit-order reversal, a lost half word or a line swap each gives a distinct mismatch. The 16-bit words differ in their low halves, which shows whether the truncation and the zero fill happen.

The serial stream and the word-select level are recorded at each rising bit-clock edge and compared position by position. This separates a missing one-bit delay and a mistimed left/right or frame-sync change from correct data. Stopping the transmit feed and then holding off the receive side drives the underflow and overflow cases.

// File: rtl/aport_pkg.sv
package aport_pkg;

  localparam int SAMPLE_W = 32;

  // Local channel carried by a slot: first half holds even channels,
  // second half holds odd channels.
  function automatic int chan_of(input int slot, input int cpl);
    int half;
    half = cpl / 2;
    if (slot < half) return 2 * slot;
    return 2 * (slot - half) + 1;
  endfunction

endpackage

// File: rtl/aport_bitclk.sv
module aport_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             fall_o,
  output logic             rise_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_m1;
  logic             wrap;

  always_comb begin
    half_m1 = (div_i >> 1);
    if (half_m1 != '0) half_m1 = half_m1 - 1'b1;
  end

  assign wrap   = (cnt_q >= half_m1);
  assign fall_o = wrap & bclk_o;
  assign rise_o = wrap & ~bclk_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_o <= ~bclk_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/aport_framer.sv
module aport_framer #(
  parameter int TDM_MODE  = 0,
  parameter int WORD_BITS = 32,
  parameter int CPL       = 2,
  localparam int SLOT_W   = (CPL > 1) ? $clog2(CPL) : 1,
  localparam int BIT_W    = $clog2(WORD_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_i,
  input  logic              rise_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] nslot_o,
  output logic              lrck_o,
  output logic              load_o,
  output logic              done_o
);

  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [SLOT_W-1:0] slot_n;
  logic              started_q;
  logic              last_bit;
  logic              lr_n;

  assign last_bit = (bit_q == BIT_W'(WORD_BITS - 1));
  assign nslot_o  = (slot_o == SLOT_W'(CPL - 1)) ? '0 : slot_o + 1'b1;
  assign load_o   = fall_i & last_bit;
  assign done_o   = rise_i & started_q & last_bit;

  always_comb begin
    if (last_bit) begin
      bit_n  = '0;
      slot_n = nslot_o;
    end else begin
      bit_n  = bit_q + 1'b1;
      slot_n = slot_o;
    end
    // Word select reflects the slot of the following bit position.
    if (TDM_MODE != 0)
      lr_n = (slot_n == SLOT_W'(CPL - 1)) && (bit_n == BIT_W'(WORD_BITS - 1));
    else if (bit_n == BIT_W'(WORD_BITS - 1))
      lr_n = (slot_n == '0);
    else
      lr_n = (slot_n != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q     <= BIT_W'(WORD_BITS - 1);
      slot_o    <= SLOT_W'(CPL - 1);
      started_q <= 1'b0;
      lrck_o    <= 1'b0;
    end else if (fall_i) begin
      bit_q     <= bit_n;
      slot_o    <= slot_n;
      started_q <= 1'b1;
      lrck_o    <= lr_n;
    end
  end

endmodule

// File: rtl/aport_tx_line.sv
module aport_tx_line #(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall_i,
  input  logic                 load_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic                 sd_o
);

  logic [WORD_BITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      sd_o <= 1'b0;
    end else if (load_i) begin
      sd_o <= word_i[WORD_BITS-1];
      sh_q <= {word_i[WORD_BITS-2:0], 1'b0};
    end else if (fall_i) begin
      sd_o <= sh_q[WORD_BITS-1];
      sh_q <= {sh_q[WORD_BITS-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/aport_rx_line.sv
module aport_rx_line #(
  parameter int WORD_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rise_i,
  input  logic        sd_i,
  output logic [31:0] word_o
);

  logic [WORD_BITS-2:0] sh_q;
  logic [WORD_BITS-1:0] full;

  assign full   = {sh_q, sd_i};
  assign word_o = 32'(full) << (32 - WORD_BITS);

  always_ff @(posedge clk) begin
    if (rst)         sh_q <= '0;
    else if (rise_i) sh_q <= {sh_q[WORD_BITS-3:0], sd_i};
  end

endmodule

// File: rtl/aport_master.sv
module aport_master import aport_pkg::*; #(
  parameter int LINES     = 2,
  parameter int WORD_BITS = 32,
  parameter int TDM_MODE  = 0,
  parameter int DIV_W     = 8,
  localparam int CPL      = (TDM_MODE != 0) ? 8 : 2,
  localparam int CH_W     = $clog2(CPL)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DIV_W-1:0]          div_i,
  output logic                      bclk_o,
  output logic                      lrck_o,
  output logic [LINES-1:0]          sd_o,
  input  logic [LINES-1:0]          sd_i,
  input  logic                      tx_valid,
  output logic                      tx_ready,
  input  logic [LINES*SAMPLE_W-1:0] tx_data,
  output logic [CH_W-1:0]           tx_chan,
  output logic                      tx_underflow,
  output logic                      rx_valid,
  input  logic                      rx_ready,
  output logic [LINES*SAMPLE_W-1:0] rx_data,
  output logic [CH_W-1:0]           rx_chan,
  output logic                      rx_overflow
);

  localparam int SLOT_W = (CPL > 1) ? $clog2(CPL) : 1;

  if (WORD_BITS != 16 && WORD_BITS != 32) begin : g_bad_width
    $error("aport_master: WORD_BITS must be 16 or 32");
  end

  logic              fall, rise, load, done;
  logic [SLOT_W-1:0] slot, nslot;
  logic [LINES*SAMPLE_W-1:0] tx_buf_q;
  logic [LINES*SAMPLE_W-1:0] rx_word;
  logic              tx_full_q;

  aport_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst(rst), .div_i(div_i),
    .bclk_o(bclk_o), .fall_o(fall), .rise_o(rise)
  );

  aport_framer #(.TDM_MODE(TDM_MODE), .WORD_BITS(WORD_BITS), .CPL(CPL)) u_framer (
    .clk(clk), .rst(rst), .fall_i(fall), .rise_i(rise),
    .slot_o(slot), .nslot_o(nslot), .lrck_o(lrck_o),
    .load_o(load), .done_o(done)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [WORD_BITS-1:0] tx_word;
    assign tx_word = tx_full_q ? tx_buf_q[l*SAMPLE_W + SAMPLE_W-1 -: WORD_BITS] : '0;

    aport_tx_line #(.WORD_BITS(WORD_BITS)) u_tx (
      .clk(clk), .rst(rst), .fall_i(fall), .load_i(load),
      .word_i(tx_word), .sd_o(sd_o[l])
    );

    aport_rx_line #(.WORD_BITS(WORD_BITS)) u_rx (
      .clk(clk), .rst(rst), .rise_i(rise), .sd_i(sd_i[l]),
      .word_o(rx_word[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  assign tx_ready = ~tx_full_q;
  assign tx_chan  = CH_W'(chan_of(int'(nslot), CPL));

  // Transmit holding register: consumed at each slot start.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full_q    <= 1'b0;
      tx_buf_q     <= '0;
      tx_underflow <= 1'b0;
    end else begin
      tx_underflow <= load & ~tx_full_q;
      if (load) tx_full_q <= 1'b0;
      if (tx_valid && !tx_full_q) begin
        tx_full_q <= 1'b1;
        tx_buf_q  <= tx_data;
      end
    end
  end

  // Receive holding register: filled at each slot completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      rx_chan     <= '0;
      rx_overflow <= 1'b0;
    end else begin
      rx_overflow <= done & rx_valid & ~rx_ready;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (done) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_word;
        rx_chan  <= CH_W'(chan_of(int'(slot), CPL));
      end
    end
  end

endmodule

// File: rtl/aport_master_chk.sv
module aport_master_chk #(
  parameter int LINES    = 2,
  parameter int TDM_MODE = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             bclk_o,
  input logic             lrck_o,
  input logic [LINES-1:0] sd_o,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_underflow,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_overflow
);

  assert_out_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !$fell(bclk_o) |-> ($stable(lrck_o) && $stable(sd_o)));

  assert_accept_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_underflow_empty_R9: assert property (@(posedge clk) disable iff (rst)
    tx_underflow |-> $past(tx_ready));

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |-> rx_valid);

  if (TDM_MODE != 0) begin : g_tdm
    assert_fs_width_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(bclk_o) |-> !(lrck_o && $past(lrck_o)));
  end

endmodule

bind aport_master aport_master_chk #(.LINES(LINES), .TDM_MODE(TDM_MODE)) u_chk (
  .clk(clk), .rst(rst), .bclk_o(bclk_o), .lrck_o(lrck_o), .sd_o(sd_o),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underflow(tx_underflow),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overflow(rx_overflow)
);

// File: tb/aport_master_test.sv
module aport_master_test;

  localparam int NV = 8;
  localparam logic [31:0] VEC_WORD [NV] = '{
    32'h8000_0001, 32'hA5C3_0F81, 32'hFFFF_FFFF, 32'h0000_0000,
    32'h7FFF_FFFE, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0001_8000};
  localparam int VEC_CHAN_A [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int VEC_CHAN_B [NV] = '{0, 2, 4, 6, 1, 3, 5, 7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] div = 8'd4;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Configuration A: two lines, 32-bit, two-channel framing
  logic        bclk_a, lrck_a, txv_a, txr_a, txu_a, rxv_a, rxr_a, rxo_a;
  logic [1:0]  sdo_a, sdi_a;
  logic [63:0] txd_a, rxd_a;
  logic [0:0]  txc_a, rxc_a;
  assign sdi_a = sdo_a;

  aport_master #(.LINES(2), .WORD_BITS(32), .TDM_MODE(0), .DIV_W(8)) uut (
    .clk(clk), .rst(rst), .div_i(div), .bclk_o(bclk_a), .lrck_o(lrck_a),
    .sd_o(sdo_a), .sd_i(sdi_a), .tx_valid(txv_a), .tx_ready(txr_a),
    .tx_data(txd_a), .tx_chan(txc_a), .tx_underflow(txu_a),
    .rx_valid(rxv_a), .rx_ready(rxr_a), .rx_data(rxd_a), .rx_chan(rxc_a),
    .rx_overflow(rxo_a));

  // Configuration B: one line, 16-bit, eight-channel framing
  logic        bclk_b, lrck_b, txv_b, txr_b, txu_b, rxv_b, rxr_b, rxo_b;
  logic [0:0]  sdo_b, sdi_b;
  logic [31:0] txd_b, rxd_b;
  logic [2:0]  txc_b, rxc_b;
  assign sdi_b = sdo_b;

  aport_master #(.LINES(1), .WORD_BITS(16), .TDM_MODE(1), .DIV_W(8)) uut_tdm (
    .clk(clk), .rst(rst), .div_i(div), .bclk_o(bclk_b), .lrck_o(lrck_b),
    .sd_o(sdo_b), .sd_i(sdi_b), .tx_valid(txv_b), .tx_ready(txr_b),
    .tx_data(txd_b), .tx_chan(txc_b), .tx_underflow(txu_b),
    .rx_valid(rxv_b), .rx_ready(rxr_b), .rx_data(rxd_b), .rx_chan(rxc_b),
    .rx_overflow(rxo_b));

  function automatic logic [31:0] line1_word(input logic [31:0] v);
    return {v[15:0], v[31:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serial recorders: one entry per rising bit-clock edge, first edge is pre-start
  logic mon_sd_a [320];
  logic mon_lr_a [320];
  logic mon_sd_b [320];
  logic mon_lr_b [320];
  int   na_pos = -1;
  int   nb_pos = -1;
  logic pre_sd_a, pre_lr_a, pre_sd_b, pre_lr_b;

  always @(posedge bclk_a) begin
    if (na_pos < 0) begin pre_sd_a = sdo_a[0]; pre_lr_a = lrck_a; end
    else if (na_pos < 320) begin mon_sd_a[na_pos] = sdo_a[0]; mon_lr_a[na_pos] = lrck_a; end
    na_pos++;
  end

  always @(posedge bclk_b) begin
    if (nb_pos < 0) begin pre_sd_b = sdo_b[0]; pre_lr_b = lrck_b; end
    else if (nb_pos < 320) begin mon_sd_b[nb_pos] = sdo_b[0]; mon_lr_b[nb_pos] = lrck_b; end
    nb_pos++;
  end

  // Receive collectors and flag counters
  logic [63:0] rx_words_a [16];
  int          rx_ch_a [16];
  logic [31:0] rx_words_b [16];
  int          rx_ch_b [16];
  int na = 0, nb = 0, uf_a = 0, uf_b = 0, of_a = 0, of_b = 0;
  int uf_snap_a = -1, uf_snap_b = -1;
  int cyc = 0, r1 = 0, r2 = 0, f1 = 0, edge_viol = 0;
  logic pb = 1'b0, p_lr = 1'b0;
  logic [1:0] p_sd = 2'b00;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (txu_a) uf_a++;
      if (txu_b) uf_b++;
      if (rxo_a) of_a++;
      if (rxo_b) of_b++;
      if (rxv_a && rxr_a && na < 16) begin
        rx_words_a[na] = rxd_a; rx_ch_a[na] = int'(rxc_a);
        if (na == NV - 1) uf_snap_a = uf_a;
        na++;
      end
      if (rxv_b && rxr_b && nb < 16) begin
        rx_words_b[nb] = rxd_b; rx_ch_b[nb] = int'(rxc_b);
        if (nb == NV - 1) uf_snap_b = uf_b;
        nb++;
      end
      if (bclk_a && !pb) begin
        if (r1 == 0) r1 = cyc; else if (r2 == 0) r2 = cyc;
      end
      if (!bclk_a && pb && r1 != 0 && f1 == 0) f1 = cyc;
      if ((lrck_a != p_lr || sdo_a != p_sd) && !(pb && !bclk_a)) edge_viol++;
      pb = bclk_a; p_lr = lrck_a; p_sd = sdo_a;
    end
  end

  task automatic feed_a();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      while (!txr_a) @(negedge clk);
      txv_a = 1'b1;
      txd_a = {line1_word(VEC_WORD[i]), VEC_WORD[i]};
      @(negedge clk);
      txv_a = 1'b0;
    end
  endtask

  task automatic feed_b();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      while (!txr_b) @(negedge clk);
      txv_b = 1'b1;
      txd_b = VEC_WORD[i];
      @(negedge clk);
      txv_b = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    txv_a = 1'b0; txd_a = '0; rxr_a = 1'b1;
    txv_b = 1'b0; txd_b = '0; rxr_b = 1'b1;
    repeat (4) @(negedge clk);
    chk(bclk_a == 0 && lrck_a == 0 && sdo_a == 0, "R2 reset pins A", {bclk_a, lrck_a, sdo_a}, 0);
    chk(txr_a == 1 && rxv_a == 0 && txu_a == 0 && rxo_a == 0 && txc_a == 0,
        "R2 reset handshake A", {txr_a, rxv_a, txu_a, rxo_a, txc_a}, 5'b10000);
    chk(bclk_b == 0 && lrck_b == 0 && sdo_b == 0 && txr_b == 1 && rxv_b == 0 && txc_b == 0,
        "R2 reset B", {bclk_b, lrck_b, sdo_b, txr_b, rxv_b, txc_b}, 8'b0001_0000);
    rst = 1'b0;
    fork
      feed_a();
      feed_b();
    join_none
    wait (na >= NV + 1 && nb >= NV + 1);
    @(negedge clk);

    chk(pre_sd_a == 0 && pre_lr_a == 0, "R2 idle before first slot A", {pre_sd_a, pre_lr_a}, 0);
    chk(pre_sd_b == 0 && pre_lr_b == 0, "R2 idle before first slot B", {pre_sd_b, pre_lr_b}, 0);
    chk(r2 - r1 == 4, "R1 bclk period", r2 - r1, 4);
    chk(f1 - r1 == 2, "R1 bclk high half", f1 - r1, 2);

    // Table walk: loopback words, lines and channel numbers
    for (int i = 0; i < NV; i++) begin
      chk(rx_words_a[i][31:0] == VEC_WORD[i], "R6 loopback line0 A", rx_words_a[i][31:0], VEC_WORD[i]);
      chk(rx_words_a[i][63:32] == line1_word(VEC_WORD[i]), "R8 loopback line1 A",
          rx_words_a[i][63:32], line1_word(VEC_WORD[i]));
      chk(rx_ch_a[i] == VEC_CHAN_A[i], "R7 channel A", rx_ch_a[i], VEC_CHAN_A[i]);
      chk(rx_words_b[i] == {VEC_WORD[i][31:16], 16'h0000}, "R6 16-bit left-aligned B",
          rx_words_b[i], {VEC_WORD[i][31:16], 16'h0000});
      chk(rx_ch_b[i] == VEC_CHAN_B[i], "R7 channel B", rx_ch_b[i], VEC_CHAN_B[i]);
    end

    // Serial stream, position by position
    for (int p = 0; p < NV * 32; p++) begin
      chk(mon_sd_a[p] == VEC_WORD[p / 32][31 - (p % 32)], "R5 MSB-first bit A", mon_sd_a[p],
          VEC_WORD[p / 32][31 - (p % 32)]);
      chk(mon_lr_a[p] == (((p + 1) % 64) >= 32), "R3 lrck level A", mon_lr_a[p], (((p + 1) % 64) >= 32));
    end
    for (int p = 0; p < NV * 16; p++) begin
      chk(mon_sd_b[p] == VEC_WORD[p / 16][31 - (p % 16)], "R5 upper-half bit B", mon_sd_b[p],
          VEC_WORD[p / 16][31 - (p % 16)]);
      chk(mon_lr_b[p] == ((p % 128) == 127), "R4 frame sync B", mon_lr_b[p], ((p % 128) == 127));
    end

    // Underflow once the feed stops
    chk(uf_snap_a == 0 && uf_snap_b == 0, "R9 no underflow while fed", {uf_snap_a, uf_snap_b}, 0);
    chk(uf_a >= 1 && uf_b >= 1, "R9 underflow flagged", {uf_a, uf_b}, 64'h1_0000_0001);
    chk(rx_words_a[NV] == 64'h0, "R9 underflow slot zero A", rx_words_a[NV], 0);
    chk(rx_words_b[NV] == 32'h0, "R9 underflow slot zero B", rx_words_b[NV], 0);

    // Overflow with the receive side stalled
    chk(of_a == 0 && of_b == 0, "R10 no overflow while drained", {of_a, of_b}, 0);
    rxr_a = 1'b0; rxr_b = 1'b0;
    repeat (3 * 32 * 4 + 8) @(negedge clk);
    chk(of_a >= 1, "R10 overflow flagged A", of_a, 1);
    chk(of_b >= 1, "R10 overflow flagged B", of_b, 1);
    chk(rxv_a == 1 && rxv_b == 1, "R10 rx_valid held", {rxv_a, rxv_b}, 2'b11);

    chk(edge_viol == 0, "R11 outputs change only at bclk fall", edge_viol, 0);
    finish_run();
  end

endmodule